// File: doc/BRIEF.md
# Paged Address Translation Unit

This block widens a 16-bit CPU address into a 20-bit physical address, which covers 1 MByte. The CPU address is split into a 4-bit page index (bits 15..12) and a 12-bit offset (bits 11..0). The offset always passes straight through. In mapped mode, the page index selects one of sixteen 8-bit frame registers, and that register supplies physical bits 19..12. The frame registers live in a sixteen-byte window at the top of a 4 KByte I/O area. They are written and read back like any other peripheral register, using the same CPU address, write strobe and data lines.

Reset leaves the unit in pass-through mode. In that mode the CPU address appears unchanged on the low sixteen physical bits, and the four upper bits are zero. The first write that lands in the register window switches the unit to mapped mode. It stays in mapped mode until the next reset. Software must therefore program the page it is executing from before, or with, that first write. The frame registers are not cleared by reset.

The translation path is purely combinational from the CPU address. Register writes and the mode change take effect on the clock edge that ends the write cycle. They therefore apply to the access in the following cycle.

Top module: `page_xlate_unit`

## Requirements
- R1: While `rst_n` is low, the unit is in pass-through mode: `phys_addr[15:0]` equals `cpu_addr` and `phys_addr[19:16]` is zero.
- R2: In pass-through mode, every CPU address maps to itself zero-extended to 20 bits, for any page index.
- R3: A cycle with `wr_en` high, `io_area` high and `cpu_addr[11:4]` equal to 0xFF writes `wr_data` into the frame register numbered `cpu_addr[3:0]` at the clock edge that ends the cycle.
- R4: A write strobe with `io_area` low, or with `cpu_addr[11:4]` not equal to 0xFF, changes no frame register and does not leave pass-through mode.
- R5: The first window write switches the unit to mapped mode at the edge that ends it. During the write cycle itself, the output is still the pass-through value.
- R6: In mapped mode, `phys_addr[19:12]` equals the frame register selected by `cpu_addr[15:12]`, and `phys_addr[11:0]` equals `cpu_addr[11:0]`.
- R7: Once set, mapped mode persists through any further traffic until `rst_n` goes low. After reset, the unit is in pass-through mode again.
- R8: `rd_data` returns the frame register numbered `cpu_addr[3:0]` when `io_area` is high and `cpu_addr[11:4]` is 0xFF. Otherwise it is zero.
- R9: Frame register contents survive reset. They can be read back after reset, and they are used again once mapped mode is re-entered.
- R10: Rewriting a frame register while mapped changes the translation of the access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the unit to pass-through mode |
| cpu_addr | input | 16 | CPU address: the page index in the top 4 bits, the offset below |
| io_area | input | 1 | High when the CPU address falls in the I/O area |
| wr_en | input | 1 | Write strobe of the current cycle |
| wr_data | input | 8 | Write data for a frame register |
| rd_data | output | 8 | Frame register readback; zero outside the window |
| phys_addr | output | 20 | Translated physical address |

## Verification
The hardest state to reach from the ports is the one just after reset, once mapped mode has been used. In that state the frame registers still hold their old values, but the output must ignore them until a new window write arrives. The stimulus first fills all sixteen frames and sweeps the address space in mapped mode. It then pulses reset and sweeps again, expecting pass-through results. Next it reads the frames back unchanged. Finally it rewrites a single frame and confirms that the untouched frames immediately drive translation again. Before any of that, writes that just miss the window are applied in pass-through mode, to show that they neither set the mode nor store data.

// File: rtl/xl_pkg.sv
package xl_pkg;
    typedef enum logic {
        XL_PASS   = 1'b0,
        XL_MAPPED = 1'b1
    } xl_mode_e;

    typedef struct packed {
        xl_mode_e mode;
    } xl_state_t;
endpackage

// File: rtl/xl_win_decode.sv
module xl_win_decode #(
    parameter int OFF_W      = 12,
    parameter int PAGE_IDX_W = 4
) (
    input  logic                  io_area,
    input  logic [OFF_W-1:0]      offset,
    output logic                  hit,
    output logic [PAGE_IDX_W-1:0] idx
);
    localparam int TAG_W = OFF_W - PAGE_IDX_W;

    // window occupies the top 2**PAGE_IDX_W bytes of the I/O area
    always_comb begin
        hit = io_area && (offset[OFF_W-1:PAGE_IDX_W] == {TAG_W{1'b1}});
        idx = offset[PAGE_IDX_W-1:0];
    end
endmodule

// File: rtl/xl_frame_file.sv
module xl_frame_file #(
    parameter int PAGE_IDX_W = 4,
    parameter int FRAME_W    = 8
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [PAGE_IDX_W-1:0]         widx,
    input  logic [FRAME_W-1:0]            wdata,
    input  logic [PAGE_IDX_W-1:0]         xl_idx,
    input  logic [PAGE_IDX_W-1:0]         rb_idx,
    output logic [FRAME_W-1:0]            xl_frame,
    output logic [FRAME_W-1:0]            rb_frame,
    output logic [(1<<PAGE_IDX_W)*FRAME_W-1:0] frames_flat
);
    localparam int NPAGE = 1 << PAGE_IDX_W;

    logic [FRAME_W-1:0] frame_d [NPAGE];
    logic [FRAME_W-1:0] frame_q [NPAGE];

    always_comb begin
        for (int i = 0; i < NPAGE; i++) begin
            frame_d[i] = frame_q[i];
            if (we && (widx == PAGE_IDX_W'(i))) begin
                frame_d[i] = wdata;
            end
        end
    end

    // contents deliberately kept across reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPAGE; i++) begin
            frame_q[i] <= frame_d[i];
        end
    end

    always_comb begin
        xl_frame = frame_q[xl_idx];
        rb_frame = frame_q[rb_idx];
    end

    for (genvar g = 0; g < NPAGE; g++) begin : g_flat
        assign frames_flat[g*FRAME_W +: FRAME_W] = frame_q[g];
    end
endmodule

// File: rtl/xl_addr_form.sv
module xl_addr_form #(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 8,
    parameter int PA_W    = 20
) (
    input  logic               mapped,
    input  logic [VA_W-1:0]    cpu_addr,
    input  logic [FRAME_W-1:0] frame,
    output logic [PA_W-1:0]    phys_addr
);
    logic [PA_W-1:0] pass_addr;

    if (PA_W > VA_W) begin : g_ext
        assign pass_addr = {{(PA_W-VA_W){1'b0}}, cpu_addr};
    end else begin : g_same
        assign pass_addr = cpu_addr[PA_W-1:0];
    end

    always_comb begin
        if (mapped) begin
            phys_addr = {frame, cpu_addr[OFF_W-1:0]};
        end else begin
            phys_addr = pass_addr;
        end
    end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
    parameter int VA_W       = 16,
    parameter int PAGE_IDX_W = 4,
    parameter int FRAME_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [VA_W-1:0]                       cpu_addr,
    input  logic                                  io_area,
    input  logic                                  wr_en,
    input  logic [FRAME_W-1:0]                    wr_data,
    output logic [FRAME_W-1:0]                    rd_data,
    output logic [VA_W-PAGE_IDX_W+FRAME_W-1:0]    phys_addr
);
    import xl_pkg::*;

    localparam int OFF_W = VA_W - PAGE_IDX_W;
    localparam int PA_W  = OFF_W + FRAME_W;
    localparam int NPAGE = 1 << PAGE_IDX_W;

    xl_state_t st_d, st_q;

    logic                    win_hit;
    logic [PAGE_IDX_W-1:0]   win_idx;
    logic                    win_we;
    logic [FRAME_W-1:0]      xl_frame;
    logic [FRAME_W-1:0]      rb_frame;
    logic [NPAGE*FRAME_W-1:0] frames_flat;
    logic                    mode_q;

    xl_win_decode #(
        .OFF_W      (OFF_W),
        .PAGE_IDX_W (PAGE_IDX_W)
    ) u_dec (
        .io_area (io_area),
        .offset  (cpu_addr[OFF_W-1:0]),
        .hit     (win_hit),
        .idx     (win_idx)
    );

    assign win_we = wr_en && win_hit;

    xl_frame_file #(
        .PAGE_IDX_W (PAGE_IDX_W),
        .FRAME_W    (FRAME_W)
    ) u_file (
        .clk         (clk),
        .we          (win_we),
        .widx        (win_idx),
        .wdata       (wr_data),
        .xl_idx      (cpu_addr[VA_W-1:OFF_W]),
        .rb_idx      (win_idx),
        .xl_frame    (xl_frame),
        .rb_frame    (rb_frame),
        .frames_flat (frames_flat)
    );

    always_comb begin
        st_d = st_q;
        if (win_we) begin
            st_d.mode = XL_MAPPED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: XL_PASS};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = (st_q.mode == XL_MAPPED);

    xl_addr_form #(
        .VA_W    (VA_W),
        .OFF_W   (OFF_W),
        .FRAME_W (FRAME_W),
        .PA_W    (PA_W)
    ) u_form (
        .mapped    (mode_q),
        .cpu_addr  (cpu_addr),
        .frame     (xl_frame),
        .phys_addr (phys_addr)
    );

    always_comb begin
        rd_data = win_hit ? rb_frame : '0;
    end
endmodule

// File: rtl/xl_checker.sv
module xl_checker #(
    parameter int VA_W       = 16,
    parameter int PAGE_IDX_W = 4,
    parameter int FRAME_W    = 8
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic [VA_W-1:0]                         cpu_addr,
    input logic                                    wr_en,
    input logic [FRAME_W-1:0]                      wr_data,
    input logic [FRAME_W-1:0]                      rd_data,
    input logic [VA_W-PAGE_IDX_W+FRAME_W-1:0]      phys_addr,
    input logic                                    mode_q,
    input logic                                    win_hit,
    input logic [(1<<PAGE_IDX_W)*FRAME_W-1:0]      frames_flat
);
    localparam int OFF_W = VA_W - PAGE_IDX_W;
    localparam int PA_W  = OFF_W + FRAME_W;

    // R1: reset forces the identity mapping
    assert_reset_pass_R1: assert property (@(posedge clk)
        !rst_n |-> (phys_addr[PA_W-1:VA_W] == '0 && phys_addr[VA_W-1:0] == cpu_addr));

    // R2: pass-through keeps upper bits clear
    assert_pass_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (phys_addr[PA_W-1:VA_W] == '0 && phys_addr[VA_W-1:0] == cpu_addr));

    // R3: window write lands in the addressed frame
    assert_frame_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win_hit) |=>
        (frames_flat[$past(cpu_addr[PAGE_IDX_W-1:0])*FRAME_W +: FRAME_W] == $past(wr_data)));

    // R4: no mode change without a window write
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !(wr_en && win_hit)) |=> !mode_q);

    // R5: window write enters mapped mode
    assert_mode_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win_hit) |=> mode_q);

    // R6: offset bits always pass unchanged; upper bits come from the frame store
    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);
    assert_frame_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (phys_addr[PA_W-1:OFF_W] ==
                    frames_flat[cpu_addr[VA_W-1:OFF_W]*FRAME_W +: FRAME_W]));

    // R7: mapped mode is sticky
    assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> mode_q);

    // R8: readback zero outside the window
    assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> rd_data == '0);
endmodule

bind page_xlate_unit xl_checker #(
    .VA_W       (VA_W),
    .PAGE_IDX_W (PAGE_IDX_W),
    .FRAME_W    (FRAME_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .phys_addr   (phys_addr),
    .mode_q      (mode_q),
    .win_hit     (win_hit),
    .frames_flat (frames_flat)
);

// File: tb/page_xlate_unit_test.sv
module page_xlate_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        io_area = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [19:0] phys_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_frame [16];

    always #4 clk = ~clk;

    page_xlate_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .io_area   (io_area),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .phys_addr (phys_addr)
    );

    task automatic chk20(input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
        end
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
        end
    endtask

    // drive at negedge, sample 2 ns later (well before the next rising edge)
    task automatic put(input logic [15:0] a, input logic io, input logic we, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; io_area = io; wr_en = we; wr_data = d;
        #2;
    endtask

    task automatic sweep_pass(input string req);
        for (int a = 0; a < 65536; a += 7) begin
            put(16'(a), 1'b0, 1'b0, 8'h00);
            chk20(req, phys_addr, {4'h0, 16'(a)});
        end
    endtask

    task automatic sweep_mapped(input string req);
        for (int a = 3; a < 65536; a += 7) begin
            put(16'(a), 1'b0, 1'b0, 8'h00);
            chk20(req, phys_addr, {exp_frame[a >> 12], 12'(a)});
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: identity during reset
        for (int p = 0; p < 16; p++) begin
            put(16'((p << 12) | 16'h0A5C), 1'b0, 1'b0, 8'h00);
            chk20("R1", phys_addr, {4'h0, 16'((p << 12) | 16'h0A5C)});
        end
        @(negedge clk); rst_n = 1'b1;

        // R2: full pass-through sweep
        sweep_pass("R2");

        // R4: near-miss writes leave pass-through intact
        put(16'hEFF3, 1'b0, 1'b1, 8'h5A);   // io_area low
        put(16'hEFE3, 1'b1, 1'b1, 8'h5A);   // offset just below window
        put(16'hE7F3, 1'b1, 1'b1, 8'h5A);   // tag bit 11 clear
        put(16'hEFF3, 1'b1, 1'b0, 8'h5A);   // strobe low
        put(16'h3123, 1'b0, 1'b0, 8'h00);
        chk20("R4", phys_addr, 20'h03123);
        put(16'hF456, 1'b0, 1'b0, 8'h00);
        chk20("R4", phys_addr, 20'h0F456);

        // R5: first window write; still pass during the write cycle
        put(16'hEFF3, 1'b1, 1'b1, 8'hA5);
        chk20("R5", phys_addr, 20'h0EFF3);
        exp_frame[3] = 8'hA5;
        put(16'h3123, 1'b0, 1'b0, 8'h00);
        chk20("R5", phys_addr, 20'hA5123);

        // R3: fill the remaining frames
        for (int i = 0; i < 16; i++) begin
            if (i != 3) begin
                exp_frame[i] = 8'((i * 37 + 11) ^ 8'h6C);
                put(16'hEFF0 | 16'(i), 1'b1, 1'b1, exp_frame[i]);
            end
        end
        put(16'h0000, 1'b0, 1'b0, 8'h00);

        // R8: readback of every frame plus off-window reads
        for (int i = 0; i < 16; i++) begin
            put(16'hEFF0 | 16'(i), 1'b1, 1'b0, 8'h00);
            chk8("R3 R8", rd_data, exp_frame[i]);
        end
        put(16'hEFE7, 1'b1, 1'b0, 8'h00);
        chk8("R8", rd_data, 8'h00);
        put(16'hEFF7, 1'b0, 1'b0, 8'h00);
        chk8("R8", rd_data, 8'h00);

        // R6: mapped sweep
        sweep_mapped("R6");

        // R10: rewrite a frame, very next access uses it
        put(16'hEFF5, 1'b1, 1'b1, 8'h3C);
        exp_frame[5] = 8'h3C;
        put(16'h5ABC, 1'b0, 1'b0, 8'h00);
        chk20("R10", phys_addr, 20'h3CABC);

        // R7: traffic keeps mapped mode, reset restores pass-through
        put(16'h1234, 1'b1, 1'b0, 8'h00);
        chk20("R7", phys_addr, {exp_frame[1], 12'h234});
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        sweep_pass("R7");

        // R9: frames survive reset
        for (int i = 0; i < 16; i++) begin
            put(16'hEFF0 | 16'(i), 1'b1, 1'b0, 8'h00);
            chk8("R9", rd_data, exp_frame[i]);
        end
        put(16'hEFF0, 1'b1, 1'b1, 8'h81);
        exp_frame[0] = 8'h81;
        put(16'h7FFF, 1'b0, 1'b0, 8'h00);
        chk20("R9", phys_addr, {exp_frame[7], 12'hFFF});
        put(16'h0001, 1'b0, 1'b0, 8'h00);
        chk20("R9", phys_addr, 20'h81001);
        sweep_mapped("R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule